// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block owns the current status word of a 32-bit core and runs the short, fixed sequence that moves the core into an exception handler and back out again. Seven request lines come in: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt (IRQ) and fast interrupt (FIQ). When one of them is accepted, the block first saves the status word into the saved-status register of the handler's mode. It then switches the status word to that mode, clears the compressed-instruction state bit and masks interrupts as the exception requires. Finally it writes the return address into that mode's link register and loads the program counter with the exception's fixed vector word.

The banked registers themselves live in the register file. The block only issues write strobes with a target mode, and it reads the saved status and link value of the current mode back through two read ports. A return request copies the saved status back into the status word and, one cycle later, loads the program counter from the link value. The status word has a fixed layout that other logic decodes: N at bit 31, Z at 30, C at 29, V at 28, IRQ mask I at bit 7, FIQ mask F at bit 6, state bit T at bit 5 and the mode in bits 4:0, with every other bit reading zero.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, psr_o reads 0x000000D3 (supervisor mode 10011, I=1, F=1, T=0, flags clear), busy is 0 and no write strobe is raised.
- R2: A pending request other than reset is accepted only in an idle cycle where insn_done is 1; a reset request is accepted in any idle cycle, whatever insn_done is.
- R3: exc_req bit 0 is reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ; when several eligible requests are pending the accepted one is the first in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R4: exc_req bit 5 is not eligible while psr_o bit 7 (I) is 1, and exc_req bit 6 is not eligible while psr_o bit 6 (F) is 1.
- R5: In the cycle after acceptance, spsr_we is 1, spsr_wmode is the handler's mode and spsr_wdata is the status word as it stood before entry.
- R6: At the end of that cycle the status word takes the handler's mode (reset and software interrupt: supervisor 10011; both aborts: abort 10111; undefined: 11011; IRQ: 10010; FIQ: 10001), T becomes 0, I becomes 1, F becomes 1 only for reset and FIQ and is otherwise kept, and N Z C V are kept; system mode 11111 is never entered.
- R7: In the following cycle lr_we and pc_we are 1, lr_wmode is the handler's mode, lr_wdata is the ret_addr value seen in the acceptance cycle and pc_wdata is VEC_BASE plus 4 times the slot (reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6, FIQ 7).
- R8: busy is 1 for the two entry cycles and for the single return cycle that follows a return; requests and return requests seen while busy have no effect.
- R9: An idle return request with no exception accepted in that cycle replaces the status word with spsr_rdata (bits 27:8 forced to zero) at that clock edge, and in the next cycle pc_we is 1 with pc_wdata equal to the lr_rdata value seen with the request.
- R10: A return request is ignored while T is 1 or while the mode is user (10000) or system (11111), and it is also ignored in a cycle where an exception is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 7 | Exception request levels, bit positions as in R3 |
| insn_done | input | 1 | The current instruction completes in this cycle |
| ret_req | input | 1 | Exception return request |
| ret_addr | input | AW | Return address to store in the link register |
| spsr_rdata | input | 32 | Saved status of the current mode, from the register file |
| lr_rdata | input | AW | Link value of the current mode, from the register file |
| psr_o | output | 32 | Current status word |
| busy | output | 1 | A sequence is in progress |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_wmode | output | 5 | Mode whose saved-status register is written |
| spsr_wdata | output | 32 | Saved-status write data |
| lr_we | output | 1 | Link register write strobe |
| lr_wmode | output | 5 | Mode whose link register is written |
| lr_wdata | output | AW | Link register write data |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | AW | New program counter |

## Verification
The assertions take for granted that the register file presents, on spsr_rdata and lr_rdata, whatever it holds for the mode on psr_o bits 4:0, and that request lines are plain levels that may be held across busy cycles without being lost or replayed. They also rely on the status only changing through this block, so a masked IRQ or FIQ can be judged from psr_o alone. The stimulus respects this by treating the two read ports as free inputs that the reference model samples in the same cycle as the design, by only offering saved-status values whose mode field is one of the seven legal encodings, and by keeping request levels up across busy windows so that the ignore-while-busy rule is exercised without any handshake.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NREQ = 7;

   // request bit positions on exc_req
   localparam logic [2:0] REQ_RST  = 3'd0;
   localparam logic [2:0] REQ_UND  = 3'd1;
   localparam logic [2:0] REQ_SWI  = 3'd2;
   localparam logic [2:0] REQ_PABT = 3'd3;
   localparam logic [2:0] REQ_DABT = 3'd4;
   localparam logic [2:0] REQ_IRQ  = 3'd5;
   localparam logic [2:0] REQ_FIQ  = 3'd6;

   // service order, highest first, as request bit indices
   localparam int PRIO_ORDER [NREQ] = '{0, 4, 6, 5, 3, 1, 2};

   // mode field encodings
   localparam logic [4:0] MODE_USR = 5'b10000;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_ABT = 5'b10111;
   localparam logic [4:0] MODE_UND = 5'b11011;
   localparam logic [4:0] MODE_SYS = 5'b11111;

   typedef struct packed {
      logic        n;
      logic        z;
      logic        c;
      logic        v;
      logic [19:0] rsvd;
      logic        i;
      logic        f;
      logic        t;
      logic [4:0]  mode;
   } psr_t;

   localparam psr_t PSR_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0,
                                  rsvd: 20'd0, i: 1'b1, f: 1'b1,
                                  t: 1'b0, mode: MODE_SVC};

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAVE   = 2'd1,
      ST_LINK   = 2'd2,
      ST_RESUME = 2'd3
   } seq_state_e;

   function automatic logic [4:0] req_mode(input logic [2:0] idx);
      logic [4:0] m;
      case (idx)
         REQ_RST, REQ_SWI:   m = MODE_SVC;
         REQ_UND:            m = MODE_UND;
         REQ_PABT, REQ_DABT: m = MODE_ABT;
         REQ_IRQ:            m = MODE_IRQ;
         default:            m = MODE_FIQ;
      endcase
      return m;
   endfunction

   function automatic logic [2:0] req_slot(input logic [2:0] idx);
      return (idx >= REQ_IRQ) ? idx + 3'd1 : idx;
   endfunction

   function automatic logic req_sets_f(input logic [2:0] idx);
      return (idx == REQ_RST) || (idx == REQ_FIQ);
   endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int N = NREQ
) (
   input  logic [N-1:0] req,
   input  logic         irq_masked,
   input  logic         fiq_masked,
   output logic [N-1:0] grant,
   output logic [2:0]   sel,
   output logic         any
);

   logic [N-1:0] elig;
   logic [N:0]   seen;

   always_comb begin
      elig = req;
      elig[REQ_IRQ] = req[REQ_IRQ] & ~irq_masked;
      elig[REQ_FIQ] = req[REQ_FIQ] & ~fiq_masked;
   end

   assign seen[0] = 1'b0;

   for (genvar k = 0; k < N; k++) begin : g_rank
      localparam int IDX = PRIO_ORDER[k];
      assign grant[IDX]  = elig[IDX] & ~seen[k];
      assign seen[k+1]   = seen[k] | elig[IDX];
   end

   assign any = seen[N];

   always_comb begin
      sel = 3'd0;
      for (int k = 0; k < N; k++) begin
         if (grant[k]) sel = 3'(k);
      end
   end

endmodule

// File: rtl/exc_vector_map.sv
module exc_vector_map
   import exc_pkg::*;
#(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] VEC_BASE = '0
) (
   input  logic [2:0]    kind,
   output logic [4:0]    mode,
   output logic          set_f,
   output logic [AW-1:0] vector
);

   localparam int PADW = AW - 5;

   logic [2:0] slot;

   always_comb begin
      slot   = req_slot(kind);
      mode   = req_mode(kind);
      set_f  = req_sets_f(kind);
      vector = VEC_BASE + {{PADW{1'b0}}, slot, 2'b00};
   end

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
   import exc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enter_en,
   input  logic [4:0] enter_mode,
   input  logic       enter_setf,
   input  logic       restore_en,
   input  psr_t       restore_val,
   output psr_t       psr
);

   psr_t psr_q;
   psr_t psr_d;

   always_comb begin
      psr_d = psr_q;
      if (enter_en) begin
         psr_d.t    = 1'b0;
         psr_d.i    = 1'b1;
         psr_d.mode = enter_mode;
         if (enter_setf) psr_d.f = 1'b1;
      end else if (restore_en) begin
         psr_d      = restore_val;
         psr_d.rsvd = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psr_q <= PSR_RESET;
      else        psr_q <= psr_d;
   end

   assign psr = psr_q;

   p_entry_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enter_en |=> (!psr_q.t && psr_q.i && psr_q.mode != MODE_SYS))
      else $error("entry left T set, I clear or system mode");

   p_entry_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enter_en |=> ({psr_q.n, psr_q.z, psr_q.c, psr_q.v} ==
                    $past({psr_q.n, psr_q.z, psr_q.c, psr_q.v})))
      else $error("entry disturbed the condition flags");

   p_entry_fkeep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_en && !enter_setf) |=> (psr_q.f == $past(psr_q.f)))
      else $error("entry changed F for an exception that keeps it");

   p_restore_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_en && !enter_en) |=> (psr_q.mode == $past(restore_val.mode)))
      else $error("return did not restore the mode field");

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] VEC_BASE = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [6:0]      exc_req,
   input  logic            insn_done,
   input  logic            ret_req,
   input  logic [AW-1:0]   ret_addr,
   input  logic [31:0]     spsr_rdata,
   input  logic [AW-1:0]   lr_rdata,
   output logic [31:0]     psr_o,
   output logic            busy,
   output logic            spsr_we,
   output logic [4:0]      spsr_wmode,
   output logic [31:0]     spsr_wdata,
   output logic            lr_we,
   output logic [4:0]      lr_wmode,
   output logic [AW-1:0]   lr_wdata,
   output logic            pc_we,
   output logic [AW-1:0]   pc_wdata
);

   initial begin
      assert (AW >= 8 && AW <= 64) else $error("AW must lie in 8..64");
      assert (VEC_BASE[4:0] == 5'd0) else $error("VEC_BASE must be 32-byte aligned");
   end

   seq_state_e    state_q;
   logic [2:0]    kind_q;
   logic [AW-1:0] addr_q;

   psr_t          psr;
   logic [NREQ-1:0] grant;
   logic [2:0]    sel;
   logic          any_elig;
   logic          take;
   logic          ret_ok;
   logic          do_ret;
   logic [4:0]    tgt_mode;
   logic          tgt_setf;
   logic [AW-1:0] tgt_vec;
   logic          idle;

   exc_arbiter #(.N(NREQ)) u_arb (
      .req        (exc_req),
      .irq_masked (psr.i),
      .fiq_masked (psr.f),
      .grant      (grant),
      .sel        (sel),
      .any        (any_elig)
   );

   exc_vector_map #(.AW(AW), .VEC_BASE(VEC_BASE)) u_vec (
      .kind   (kind_q),
      .mode   (tgt_mode),
      .set_f  (tgt_setf),
      .vector (tgt_vec)
   );

   assign idle   = (state_q == ST_IDLE);
   assign take   = idle && any_elig && (grant[REQ_RST] || insn_done);
   assign ret_ok = !psr.t && (psr.mode != MODE_USR) && (psr.mode != MODE_SYS);
   assign do_ret = idle && !take && ret_req && ret_ok;

   exc_status_reg u_psr (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_en    (state_q == ST_SAVE),
      .enter_mode  (tgt_mode),
      .enter_setf  (tgt_setf),
      .restore_en  (do_ret),
      .restore_val (psr_t'(spsr_rdata)),
      .psr         (psr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= REQ_RST;
         addr_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  state_q <= ST_SAVE;
                  kind_q  <= sel;
                  addr_q  <= ret_addr;
               end else if (do_ret) begin
                  state_q <= ST_RESUME;
                  addr_q  <= lr_rdata;
               end
            end
            ST_SAVE:  state_q <= ST_LINK;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      spsr_we    = (state_q == ST_SAVE);
      spsr_wmode = tgt_mode;
      spsr_wdata = psr;
      lr_we      = (state_q == ST_LINK);
      lr_wmode   = psr.mode;
      lr_wdata   = addr_q;
      pc_we      = (state_q == ST_LINK) || (state_q == ST_RESUME);
      pc_wdata   = (state_q == ST_LINK) ? tgt_vec : addr_q;
   end

   assign psr_o = psr;
   assign busy  = !idle;

   p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant))
      else $error("more than one request granted");

   p_done_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !insn_done && !exc_req[REQ_RST]) |=> !spsr_we)
      else $error("entry started without a completed instruction");

   p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && psr_o[7] && exc_req == 7'b0100000) |=> !spsr_we)
      else $error("IRQ taken while masked");

   p_save_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we |=> (lr_we && pc_we && lr_wmode == $past(spsr_wmode)))
      else $error("link and vector write did not follow the status save");

   p_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (spsr_we || lr_we || pc_we) |-> busy)
      else $error("write strobe outside a sequence");

   p_ret_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ret_req && psr_o[5]) |=> !pc_we)
      else $error("return honoured while T was set");

endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [6:0]      exc_req = '0;
   logic            insn_done = 1'b0;
   logic            ret_req = 1'b0;
   logic [AW-1:0]   ret_addr = '0;
   logic [31:0]     spsr_rdata = '0;
   logic [AW-1:0]   lr_rdata = '0;
   logic [31:0]     psr_o;
   logic            busy;
   logic            spsr_we;
   logic [4:0]      spsr_wmode;
   logic [31:0]     spsr_wdata;
   logic            lr_we;
   logic [4:0]      lr_wmode;
   logic [AW-1:0]   lr_wdata;
   logic            pc_we;
   logic [AW-1:0]   pc_wdata;

   always #10 clk = ~clk;

   exc_entry_ctrl #(.AW(AW), .VEC_BASE('0)) u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .insn_done(insn_done),
      .ret_req(ret_req), .ret_addr(ret_addr), .spsr_rdata(spsr_rdata),
      .lr_rdata(lr_rdata), .psr_o(psr_o), .busy(busy), .spsr_we(spsr_we),
      .spsr_wmode(spsr_wmode), .spsr_wdata(spsr_wdata), .lr_we(lr_we),
      .lr_wmode(lr_wmode), .lr_wdata(lr_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   typedef struct {
      int          kind;   // 1 save, 2 link, 3 resume
      logic [4:0]  mode;
      logic [31:0] sdata;
      logic [31:0] addr;
      logic [31:0] pc;
      bit          setf;
   } exp_t;

   exp_t        q[$];
   logic [31:0] m_psr = 32'h0000_00D3;
   int          ORD [7] = '{0, 4, 6, 5, 3, 1, 2};

   function automatic logic [4:0] mode_for(int k);
      case (k)
         0, 2:    return 5'b10011;
         1:       return 5'b11011;
         3, 4:    return 5'b10111;
         5:       return 5'b10010;
         default: return 5'b10001;
      endcase
   endfunction

   function automatic int slot_for(int k);
      return (k >= 5) ? k + 1 : k;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_psr = 32'h0000_00D3;
         q.delete();
      end else if (q.size() != 0) begin
         exp_t r;
         r = q.pop_front();
         if (r.kind == 1) begin
            m_psr[4:0] = r.mode;
            m_psr[5]   = 1'b0;
            m_psr[7]   = 1'b1;
            if (r.setf) m_psr[6] = 1'b1;
         end
      end else begin
         int pick;
         pick = -1;
         foreach (ORD[k]) begin
            int b;
            bit ok;
            b  = ORD[k];
            ok = exc_req[b];
            if (b == 5 && m_psr[7]) ok = 0;
            if (b == 6 && m_psr[6]) ok = 0;
            if (ok && pick < 0) pick = b;
         end
         if (pick >= 0 && (pick == 0 || insn_done)) begin
            exp_t s;
            exp_t l;
            s.kind = 1; s.mode = mode_for(pick); s.sdata = m_psr; s.addr = 0;
            s.pc = 0; s.setf = (pick == 0 || pick == 6);
            l = s;
            l.kind = 2; l.addr = ret_addr; l.pc = 32'(slot_for(pick) * 4);
            q.push_back(s);
            q.push_back(l);
         end else if (ret_req && !m_psr[5] && m_psr[4:0] != 5'b10000 && m_psr[4:0] != 5'b11111) begin
            exp_t r;
            m_psr = spsr_rdata & 32'hF000_00FF;
            r.kind = 3; r.mode = 0; r.sdata = 0; r.addr = 0; r.pc = lr_rdata; r.setf = 0;
            q.push_back(r);
         end
      end
   end

   // per-cycle comparison, away from the active edge
   logic [31:0] last_pc = '0;
   always @(posedge clk) if (pc_we) last_pc <= pc_wdata;

   always @(negedge clk) begin
      if (rst_n) begin
         int  k;
         k = (q.size() != 0) ? q[0].kind : 0;
         check(psr_o == m_psr, "R6", "status word", psr_o, m_psr);
         check(busy == (k != 0), "R8", "busy", 32'(busy), 32'(k != 0));
         check(spsr_we == (k == 1), "R5", "spsr_we", 32'(spsr_we), 32'(k == 1));
         check(lr_we == (k == 2), "R7", "lr_we", 32'(lr_we), 32'(k == 2));
         check(pc_we == (k == 2 || k == 3), "R9", "pc_we", 32'(pc_we), 32'(k == 2 || k == 3));
         if (k == 1) begin
            check(spsr_wmode == q[0].mode, "R5", "spsr_wmode", 32'(spsr_wmode), 32'(q[0].mode));
            check(spsr_wdata == q[0].sdata, "R5", "spsr_wdata", spsr_wdata, q[0].sdata);
         end
         if (k == 2) begin
            check(lr_wmode == q[0].mode, "R7", "lr_wmode", 32'(lr_wmode), 32'(q[0].mode));
            check(lr_wdata == q[0].addr, "R7", "lr_wdata", lr_wdata, q[0].addr);
         end
         if (k == 2 || k == 3)
            check(pc_wdata == q[0].pc, "R7", "pc_wdata", pc_wdata, q[0].pc);
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      step(3);
      check(psr_o == 32'h0000_00D3 && !busy && !pc_we && !lr_we && !spsr_we,
            "R1", "status held in reset", psr_o, 32'h0000_00D3);
      rst_n = 1'b1;
      step(1);
      check(psr_o == 32'h0000_00D3, "R1", "status after reset", psr_o, 32'h0000_00D3);

      // masked IRQ
      exc_req = 7'b0100000; insn_done = 1'b1;
      step(4);
      check(busy == 1'b0 && psr_o == 32'h0000_00D3, "R4", "IRQ while I=1", psr_o, 32'h0000_00D3);
      exc_req = '0; insn_done = 1'b0;

      // return into user mode with N set
      spsr_rdata = 32'h8000_0010; lr_rdata = 32'h0000_0100; ret_req = 1'b1;
      step(1); ret_req = 1'b0; step(2);
      check(psr_o == 32'h8000_0010, "R9", "restored status", psr_o, 32'h8000_0010);
      check(last_pc == 32'h0000_0100, "R9", "return pc", last_pc, 32'h0000_0100);

      // IRQ waits for instruction completion
      exc_req = 7'b0100000; ret_addr = 32'h0000_0204;
      step(3);
      check(busy == 1'b0, "R2", "no entry without insn_done", 32'(busy), 32'd0);
      insn_done = 1'b1; step(1); exc_req = '0; insn_done = 1'b0; step(2);
      check(psr_o == 32'h8000_0092, "R6", "IRQ entry status", psr_o, 32'h8000_0092);
      check(last_pc == 32'h0000_0018, "R7", "IRQ vector", last_pc, 32'h0000_0018);

      // several at once: data abort wins
      exc_req = 7'b1111000; insn_done = 1'b1; step(1); exc_req = '0; step(2);
      check(last_pc == 32'h0000_0010, "R3", "data abort wins", last_pc, 32'h0000_0010);
      check(psr_o == 32'h8000_0097, "R3", "abort mode status", psr_o, 32'h8000_0097);

      // return to T=1 user state, then a blocked return
      spsr_rdata = 32'h0000_0030; ret_req = 1'b1; step(1); ret_req = 1'b0; step(2);
      spsr_rdata = 32'h0000_0013; lr_rdata = 32'h0000_0300; ret_req = 1'b1;
      step(1); ret_req = 1'b0; step(2);
      check(psr_o == 32'h0000_0030, "R10", "return with T=1 ignored", psr_o, 32'h0000_0030);
      check(last_pc == 32'h0000_0100, "R10", "no pc load on blocked return", last_pc, 32'h0000_0100);

      // FIQ entry sets F and clears T
      exc_req = 7'b1000000; step(1); exc_req = '0; step(2);
      check(psr_o == 32'h0000_00D1, "R6", "FIQ entry status", psr_o, 32'h0000_00D1);
      check(last_pc == 32'h0000_001C, "R7", "FIQ vector", last_pc, 32'h0000_001C);

      // undefined beats software interrupt
      exc_req = 7'b0000110; step(1); exc_req = '0; step(2);
      check(last_pc == 32'h0000_0004, "R3", "undefined beats SWI", last_pc, 32'h0000_0004);
      check(psr_o == 32'h0000_00DB, "R6", "undefined mode status", psr_o, 32'h0000_00DB);

      // return to user, then a return from user mode
      spsr_rdata = 32'h0000_0010; lr_rdata = 32'h0000_0400; ret_req = 1'b1;
      step(1); ret_req = 1'b0; step(2);
      spsr_rdata = 32'h0000_0013; lr_rdata = 32'h0000_0500; ret_req = 1'b1;
      step(1); ret_req = 1'b0; step(2);
      check(psr_o == 32'h0000_0010, "R10", "return in user mode ignored", psr_o, 32'h0000_0010);
      check(last_pc == 32'h0000_0400, "R10", "user-mode return no pc", last_pc, 32'h0000_0400);

      // reset request without insn_done
      insn_done = 1'b0; exc_req = 7'b0000001; step(1); exc_req = '0; step(2);
      check(psr_o == 32'h0000_00D3, "R2", "reset taken at once", psr_o, 32'h0000_00D3);
      check(last_pc == 32'h0000_0000, "R2", "reset vector", last_pc, 32'h0000_0000);

      // inputs ignored while busy
      exc_req = 7'b0000100; insn_done = 1'b1; step(1);
      exc_req = 7'b0001000; spsr_rdata = 32'h0000_0010; lr_rdata = 32'h0000_0600; ret_req = 1'b1;
      step(2); exc_req = '0; ret_req = 1'b0; insn_done = 1'b0; step(1);
      check(psr_o == 32'h0000_00D3, "R8", "busy ignores return", psr_o, 32'h0000_00D3);
      check(last_pc == 32'h0000_0008, "R8", "busy ignores requests", last_pc, 32'h0000_0008);

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] modes [7];
         logic [6:0] r;
         modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
         r = '0;
         for (int b = 1; b < 7; b++) r[b] = ($urandom % 8) == 0;
         r[0] = ($urandom % 64) == 0;
         exc_req    = r;
         insn_done  = $urandom % 2;
         ret_req    = ($urandom % 4) == 0;
         ret_addr   = $urandom;
         lr_rdata   = $urandom;
         spsr_rdata = {4'($urandom), 20'($urandom), 3'($urandom), modes[$urandom % 7]};
         step(1);
      end
      exc_req = '0; ret_req = 1'b0; step(4);

      done = 1;
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         report();
      end
   end

endmodule